// File: doc/BRIEF.md
# Power Rail Sequencing Controller

This block is the board-level supervisor for a large target device that is fed by six switching regulators. It watches a stream of 12-bit voltage readings. Each reading is tagged with a 4-bit channel index, and readings are assumed to arrive round-robin at roughly one every half microsecond. From these readings it decides when each regulator may be switched on and when the target may leave reset. Channel 0 carries the line-side input supply. Channels 1 to 6 carry the load side of the six regulated rails, and channel k belongs to enable bit k-1.

A power-up request first waits until the input supply reads inside its window. The controller then turns the regulators on one at a time, lowest enable bit first. It moves to the next regulator only after that rail's own channel reads good. Once the last rail is confirmed, it releases the target reset. From then on every rail stays under watch. Two back-to-back out-of-window readings on any rail drop all rails and the reset, and the bring-up then starts again from the input check on its own. A power-down request asserts reset first and then removes the rails in reverse order, one every `OFF_GAP` cycles. A rail that does not settle within `SETTLE_CYC` cycles shuts everything off and latches a fault. The fault stays set until the next power-up request.

Per-channel lower and upper limits are written through a simple write port, and both limits are inclusive.

Top module: `rail_sequencer`

## Requirements
- R1: Readings are 12 bits wide and carry a 4-bit channel index. Only channels 0 to 6 are evaluated. A reading on channel 7 to 15 has no effect on enables, reset or fault.
- R2: After `up_req`, no enable is asserted until a channel-0 reading lies inside its window. Once it does, `rail_en` becomes 6'b000001.
- R3: Enable bits rise one at a time, from bit 0 up to bit 5. `rail_en` is always of the form 2^k-1.
- R4: With enables 0..k-1 on, bit k turns on only after an in-window reading on channel k. Readings on other channels, or out-of-window readings on channel k, do not advance the sequence.
- R5: `target_rst_n` goes high only after channel 6 reads good with all six enables on. While it is high, `rail_en` is 6'b111111.
- R6: While running, two consecutive out-of-window readings on the same channel (0 to 6) clear all enables and drive `target_rst_n` low. The controller then restarts from the channel-0 check without a new request.
- R7: A single out-of-window reading that is followed by an in-window reading on the same channel causes no reinitialization.
- R8: `down_req` while running drives `target_rst_n` low in the next cycle, before any rail is dropped. The enables then clear from bit 5 down to bit 0, one every `OFF_GAP` cycles, ending with all off.
- R9: If the rail being brought up is not good within `SETTLE_CYC` cycles, all enables clear and `fault` latches high. `fault` is cleared by the next `up_req`, which restarts at the channel-0 check.
- R10: Per-channel limits are written with `thr_wr` (`thr_hi`=0 selects the lower limit, 1 the upper). A reading equal to either limit counts as in window, and one code beyond either limit is out of window.
- R11: `down_req` during bring-up clears the enables that are already on, highest bit first.
- R12: `up_req` while running, and `down_req` while off or faulted, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | A reading is present this cycle |
| smp_chan | input | 4 | Channel index of the reading |
| smp_data | input | 12 | Voltage reading |
| thr_wr | input | 1 | Write one limit |
| thr_chan | input | 4 | Channel whose limit is written |
| thr_hi | input | 1 | 0: lower limit, 1: upper limit |
| thr_val | input | 12 | Limit value |
| up_req | input | 1 | Power-up request (one-cycle pulse) |
| down_req | input | 1 | Power-down request (one-cycle pulse) |
| rail_en | output | 6 | Regulator enables, bit k-1 feeds the rail read on channel k |
| target_rst_n | output | 1 | Active-low reset to the target device |
| fault | output | 1 | Latched settle-timeout fault |

## Verification
The bench builds the controller with `SETTLE_CYC` = 40 and `OFF_GAP` = 4, keeping six rails and a two-reading debounce. With these values the settle timeout fires within a few dozen cycles, so the latched fault and its clearing can be reached in a short run. They also make each step of the reverse power-down visible, so the order of the dropped bits and the reset-first rule can be checked edge by edge. Limits of 1000 and 3000 put the inclusive boundary codes and the codes one beyond them into the directed stimulus.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
    localparam int SAMPLE_W = 12;
    localparam int CHAN_W   = 4;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_LINE,
        ST_RAMP,
        ST_RUN,
        ST_DOWN,
        ST_FAULT
    } seq_state_e;

    // Verdict on one reading, one cycle after it arrived
    typedef struct packed {
        logic              valid;
        logic [CHAN_W-1:0] chan;
        logic              in_win;
        logic              fault;   // debounced out-of-window
    } rail_evt_t;
endpackage

// File: rtl/rail_window_check.sv
module rail_window_check
    import pwrseq_pkg::*;
#(
    parameter int N_CH     = 7,
    parameter int DEBOUNCE = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [CHAN_W-1:0]   smp_chan,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                thr_wr,
    input  logic [CHAN_W-1:0]   thr_chan,
    input  logic                thr_hi,
    input  logic [SAMPLE_W-1:0] thr_val,
    output rail_evt_t           evt
);
    localparam int IDX_W  = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam int MISS_W = $clog2(DEBOUNCE + 1);

    typedef struct {
        logic [SAMPLE_W-1:0] lo   [N_CH];
        logic [SAMPLE_W-1:0] hi   [N_CH];
        logic [MISS_W-1:0]   miss [N_CH];
        rail_evt_t           evt;
    } chk_t;

    chk_t s_q, s_d;

    logic [N_CH-1:0] in_win;
    logic [IDX_W-1:0] smp_sel, thr_sel;
    logic smp_hit, thr_hit;

    assign smp_sel = smp_chan[IDX_W-1:0];
    assign thr_sel = thr_chan[IDX_W-1:0];
    assign smp_hit = smp_valid && (int'(smp_chan) < N_CH);
    assign thr_hit = thr_wr && (int'(thr_chan) < N_CH);

    // Inclusive window compare for every channel
    genvar c;
    generate
        for (c = 0; c < N_CH; c++) begin : g_cmp
            assign in_win[c] = (smp_data >= s_q.lo[c]) && (smp_data <= s_q.hi[c]);
        end
    endgenerate

    always_comb begin
        s_d     = s_q;
        s_d.evt = '0;
        if (thr_hit) begin
            if (thr_hi) s_d.hi[thr_sel] = thr_val;
            else        s_d.lo[thr_sel] = thr_val;
        end
        if (smp_hit) begin
            s_d.evt.valid  = 1'b1;
            s_d.evt.chan   = smp_chan;
            s_d.evt.in_win = in_win[smp_sel];
            if (in_win[smp_sel]) begin
                s_d.miss[smp_sel] = '0;
            end else begin
                if (int'(s_q.miss[smp_sel]) < DEBOUNCE)
                    s_d.miss[smp_sel] = s_q.miss[smp_sel] + MISS_W'(1);
                s_d.evt.fault = (int'(s_q.miss[smp_sel]) + 1 >= DEBOUNCE);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CH; i++) begin
                s_q.lo[i]   <= '0;
                s_q.hi[i]   <= '1;
                s_q.miss[i] <= '0;
            end
            s_q.evt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign evt = s_q.evt;

    // A verdict only follows a reading on a monitored channel
    assert_evt_from_sample_R1: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.evt.valid |-> ($past(smp_valid) && (int'($past(smp_chan)) < N_CH)));

    // A debounced fault is never an in-window verdict
    assert_fault_out_of_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.evt.fault |-> (s_q.evt.valid && !s_q.evt.in_win));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import pwrseq_pkg::*;
#(
    parameter int N_RAILS    = 6,
    parameter int SETTLE_CYC = 20000,
    parameter int OFF_GAP    = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  rail_evt_t          evt,
    input  logic               up_req,
    input  logic               down_req,
    output logic [N_RAILS-1:0] rail_en,
    output logic               target_rst_n,
    output logic               fault
);
    localparam int IDX_W = (N_RAILS > 1) ? $clog2(N_RAILS) : 1;
    localparam int TMAX  = (SETTLE_CYC > OFF_GAP) ? SETTLE_CYC : OFF_GAP;
    localparam int TMR_W = (TMAX > 1) ? $clog2(TMAX) : 1;

    typedef struct packed {
        seq_state_e         st;
        logic [IDX_W-1:0]   idx;
        logic [TMR_W-1:0]   tmr;
        logic [N_RAILS-1:0] en;
        logic               trst;
        logic               flt;
    } fsm_t;

    fsm_t s_q, s_d;
    logic [IDX_W-1:0] nxt;
    logic ok_next, bad_checked, bad_any;

    assign nxt         = s_q.idx + IDX_W'(1);
    // Good reading on the rail currently settling (channel idx+1)
    assign ok_next     = evt.valid && evt.in_win && (int'(evt.chan) == int'(s_q.idx) + 1);
    // Debounced fault on a rail already confirmed (channel 0..idx)
    assign bad_checked = evt.valid && evt.fault && (int'(evt.chan) <= int'(s_q.idx));
    assign bad_any     = evt.valid && evt.fault;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_OFF: begin
                s_d.en   = '0;
                s_d.trst = 1'b0;
                if (up_req) s_d.st = ST_LINE;
            end
            ST_LINE: begin
                if (down_req) begin
                    s_d.st = ST_OFF;
                end else if (evt.valid && evt.in_win && evt.chan == '0) begin
                    s_d.st    = ST_RAMP;
                    s_d.idx   = '0;
                    s_d.tmr   = '0;
                    s_d.en[0] = 1'b1;
                end
            end
            ST_RAMP: begin
                if (down_req) begin
                    s_d.st  = ST_DOWN;
                    s_d.tmr = '0;
                end else if (bad_checked) begin
                    s_d.st = ST_LINE;
                    s_d.en = '0;
                end else if (ok_next) begin
                    s_d.tmr = '0;
                    if (s_q.idx == IDX_W'(N_RAILS - 1)) begin
                        s_d.st   = ST_RUN;
                        s_d.trst = 1'b1;
                    end else begin
                        s_d.idx     = nxt;
                        s_d.en[nxt] = 1'b1;
                    end
                end else if (s_q.tmr == TMR_W'(SETTLE_CYC - 1)) begin
                    s_d.st  = ST_FAULT;
                    s_d.en  = '0;
                    s_d.flt = 1'b1;
                end else begin
                    s_d.tmr = s_q.tmr + TMR_W'(1);
                end
            end
            ST_RUN: begin
                if (down_req) begin
                    s_d.st   = ST_DOWN;
                    s_d.idx  = IDX_W'(N_RAILS - 1);
                    s_d.tmr  = '0;
                    s_d.trst = 1'b0;
                end else if (bad_any) begin
                    s_d.st   = ST_LINE;
                    s_d.en   = '0;
                    s_d.trst = 1'b0;
                end
            end
            ST_DOWN: begin
                s_d.trst = 1'b0;
                if (s_q.tmr == TMR_W'(OFF_GAP - 1)) begin
                    s_d.tmr         = '0;
                    s_d.en[s_q.idx] = 1'b0;
                    if (s_q.idx == '0) s_d.st = ST_OFF;
                    else               s_d.idx = s_q.idx - IDX_W'(1);
                end else begin
                    s_d.tmr = s_q.tmr + TMR_W'(1);
                end
            end
            ST_FAULT: begin
                s_d.en   = '0;
                s_d.trst = 1'b0;
                if (up_req) begin
                    s_d.st  = ST_LINE;
                    s_d.flt = 1'b0;
                end
            end
            default: s_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_OFF;
        end else begin
            s_q <= s_d;
        end
    end

    assign rail_en      = s_q.en;
    assign target_rst_n = s_q.trst;
    assign fault        = s_q.flt;

    assert_thermometer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.en & (s_q.en + N_RAILS'(1))) == '0);

    assert_one_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(s_q.en & ~$past(s_q.en)) <= 1);

    assert_release_all_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.trst |-> (&s_q.en));

    assert_fault_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.flt |-> (s_q.en == '0 && !s_q.trst));

    assert_reset_before_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones($past(s_q.en) & ~s_q.en) == 1) |-> !$past(s_q.trst));
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
    import pwrseq_pkg::*;
#(
    parameter int N_RAILS    = 6,
    parameter int SETTLE_CYC = 20000,
    parameter int OFF_GAP    = 1000,
    parameter int DEBOUNCE   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [CHAN_W-1:0]   smp_chan,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                thr_wr,
    input  logic [CHAN_W-1:0]   thr_chan,
    input  logic                thr_hi,
    input  logic [SAMPLE_W-1:0] thr_val,
    input  logic                up_req,
    input  logic                down_req,
    output logic [N_RAILS-1:0]  rail_en,
    output logic                target_rst_n,
    output logic                fault
);
    localparam int N_CH = N_RAILS + 1;

    rail_evt_t evt;

    rail_window_check #(
        .N_CH     (N_CH),
        .DEBOUNCE (DEBOUNCE)
    ) u_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_chan  (smp_chan),
        .smp_data  (smp_data),
        .thr_wr    (thr_wr),
        .thr_chan  (thr_chan),
        .thr_hi    (thr_hi),
        .thr_val   (thr_val),
        .evt       (evt)
    );

    seq_fsm #(
        .N_RAILS    (N_RAILS),
        .SETTLE_CYC (SETTLE_CYC),
        .OFF_GAP    (OFF_GAP)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt          (evt),
        .up_req       (up_req),
        .down_req     (down_req),
        .rail_en      (rail_en),
        .target_rst_n (target_rst_n),
        .fault        (fault)
    );
endmodule

// File: tb/test_rail_sequencer.sv
module test_rail_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 40;
    localparam int GAP        = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [3:0]  smp_chan = '0;
    logic [11:0] smp_data = '0;
    logic        thr_wr = 1'b0;
    logic [3:0]  thr_chan = '0;
    logic        thr_hi = 1'b0;
    logic [11:0] thr_val = '0;
    logic        up_req = 1'b0;
    logic        down_req = 1'b0;
    logic [5:0]  rail_en;
    logic        target_rst_n;
    logic        fault;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rail_sequencer #(
        .N_RAILS(6), .SETTLE_CYC(SETTLE), .OFF_GAP(GAP), .DEBOUNCE(2)
    ) i_rail_sequencer (
        .clk(clk), .rst_n(rst_n),
        .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data),
        .thr_wr(thr_wr), .thr_chan(thr_chan), .thr_hi(thr_hi), .thr_val(thr_val),
        .up_req(up_req), .down_req(down_req),
        .rail_en(rail_en), .target_rst_n(target_rst_n), .fault(fault)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input int ch, input int val);
        @(negedge clk);
        smp_valid = 1'b1; smp_chan = 4'(ch); smp_data = 12'(val);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic pulse_up();
        @(negedge clk); up_req = 1'b1;
        @(negedge clk); up_req = 1'b0;
    endtask

    task automatic pulse_down();
        @(negedge clk); down_req = 1'b1;
        @(negedge clk); down_req = 1'b0;
    endtask

    task automatic write_thr(input int ch, input bit hi, input int val);
        @(negedge clk);
        thr_wr = 1'b1; thr_chan = 4'(ch); thr_hi = hi; thr_val = 12'(val);
        @(negedge clk);
        thr_wr = 1'b0;
    endtask

    task automatic ramp_all();
        send(0, 2000);
        for (int r = 1; r <= 6; r++) send(r, 2000);
        tick(2);
    endtask

    // Follow a power-down: each change must clear exactly the top bit
    task automatic watch_down(input int start, input int drops_exp, input string req);
        int prev = start;
        int drops = 0;
        for (int i = 0; i < 60; i++) begin
            tick(1);
            if (int'(rail_en) != prev) begin
                chk(int'(rail_en) == (prev >> 1), req, rail_en, prev >> 1);
                chk(target_rst_n == 1'b0, req, target_rst_n, 0);
                prev = int'(rail_en);
                drops++;
            end
        end
        chk(drops == drops_exp, req, drops, drops_exp);
        chk(rail_en == 6'd0, req, rail_en, 0);
    endtask

    task automatic t_reset();
        chk(rail_en == 6'd0, "R3 reset", rail_en, 0);
        chk(target_rst_n == 1'b0, "R5 reset", target_rst_n, 0);
        chk(fault == 1'b0, "R9 reset", fault, 0);
        pulse_down();
        tick(3);
        chk(rail_en == 6'd0 && !target_rst_n, "R12 down while off", rail_en, 0);
    endtask

    task automatic t_bringup();
        for (int ch = 0; ch <= 6; ch++) begin
            write_thr(ch, 1'b0, 1000);
            write_thr(ch, 1'b1, 3000);
        end
        pulse_up();
        send(0, 999);  tick(2);
        chk(rail_en == 6'd0, "R2 line below window", rail_en, 0);
        send(0, 3001); tick(2);
        chk(rail_en == 6'd0, "R10 line above window", rail_en, 0);
        send(0, 1000); tick(2);
        chk(rail_en == 6'd1, "R2 R10 line at lower limit", rail_en, 1);
        send(2, 2000); tick(2);
        chk(rail_en == 6'd1, "R4 wrong channel", rail_en, 1);
        send(1, 3001); tick(2);
        chk(rail_en == 6'd1, "R4 rail out of window", rail_en, 1);
        send(1, 3000); tick(2);
        chk(rail_en == 6'd3, "R3 R10 rail at upper limit", rail_en, 3);
        for (int r = 2; r <= 5; r++) begin
            send(r, 2000); tick(2);
            chk(int'(rail_en) == (1 << (r + 1)) - 1, "R3 step", rail_en, (1 << (r + 1)) - 1);
            chk(target_rst_n == 1'b0, "R5 held in reset", target_rst_n, 0);
        end
        send(6, 2000); tick(2);
        chk(rail_en == 6'h3f && target_rst_n, "R5 release", {target_rst_n, rail_en}, 8'h7f);
    endtask

    task automatic t_noise();
        send(3, 3001); send(3, 2999); tick(2);
        chk(rail_en == 6'h3f && target_rst_n, "R7 single glitch", {target_rst_n, rail_en}, 8'h7f);
        send(9, 0); send(9, 0); send(15, 0); send(15, 0); tick(2);
        chk(rail_en == 6'h3f && target_rst_n, "R1 high channels ignored", {target_rst_n, rail_en}, 8'h7f);
        pulse_up(); tick(2);
        chk(rail_en == 6'h3f && target_rst_n, "R12 up while running", {target_rst_n, rail_en}, 8'h7f);
    endtask

    task automatic t_dip();
        send(4, 3500); tick(2);
        chk(rail_en == 6'h3f, "R7 first miss", rail_en, 6'h3f);
        send(4, 3500); tick(2);
        chk(rail_en == 6'd0 && !target_rst_n, "R6 dip drops all", {target_rst_n, rail_en}, 0);
        ramp_all();
        chk(rail_en == 6'h3f && target_rst_n, "R6 restart without request", {target_rst_n, rail_en}, 8'h7f);
    endtask

    task automatic t_down();
        pulse_down();
        chk(target_rst_n == 1'b0, "R8 reset first", target_rst_n, 0);
        chk(rail_en == 6'h3f, "R8 rails still on", rail_en, 6'h3f);
        watch_down(6'h3f, 6, "R8 reverse order");
    endtask

    task automatic t_timeout();
        pulse_up();
        send(0, 2000); tick(2);
        chk(rail_en == 6'd1, "R9 first rail on", rail_en, 1);
        tick(SETTLE - 10);
        chk(fault == 1'b0 && rail_en == 6'd1, "R9 before timeout", {fault, rail_en}, 1);
        tick(20);
        chk(fault == 1'b1 && rail_en == 6'd0, "R9 timeout fault", {fault, rail_en}, 8'h40);
        pulse_down(); tick(2);
        chk(fault == 1'b1 && rail_en == 6'd0, "R12 down while faulted", {fault, rail_en}, 8'h40);
        pulse_up(); tick(1);
        chk(fault == 1'b0 && rail_en == 6'd0, "R9 fault cleared", {fault, rail_en}, 0);
        send(0, 2000); tick(2);
        chk(rail_en == 6'd1, "R9 restart at line check", rail_en, 1);
    endtask

    task automatic t_abort();
        send(1, 2000); tick(2);
        chk(rail_en == 6'd3, "R11 partial ramp", rail_en, 3);
        pulse_down();
        watch_down(3, 2, "R11 abort order");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_bringup();
        t_noise();
        t_dip();
        t_down();
        t_timeout();
        t_abort();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule